// File: doc/BRIEF.md
# Parallel Video to Stream Bridge

This block turns a parallel pixel bus into a stream master interface in the AXI4-Stream style. The pixel bus carries one pixel per enabled clock, together with an active-video qualifier and a vertical-sync qualifier. Each accepted pixel becomes exactly one stream beat. The first pixel of a frame is marked on TUSER, and the final pixel of each active line is marked on TLAST. Every colour component is widened to a byte-aligned field with zeros above it.

The whole block runs on one clock. A synchronous clock enable freezes all state and holds every output level. A synchronous active-low reset overrides the enable. Between the pixel side and the stream side sits a small FIFO that absorbs sink backpressure. A pixel that arrives while the FIFO is full is discarded, and a sticky flag records the loss.

A line end can only be known once the following sample has been seen, so every pixel waits in a one-deep holding register for one enabled cycle before it enters the FIFO.

Top module: `vsb_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state. After that edge, `m_tvalid` is 0, `overflow` is 0, the FIFO is empty, the holding register is empty and no vertical sync is remembered.
- R2: At an edge where `clk_en` is 0, no input is sampled and no state changes. All outputs keep the levels they had before that edge.
- R3: Reset takes effect at an edge where `clk_en` is 0, with the same result as R1.
- R4: A pixel is accepted at an enabled edge when `vid_active` is 1, `vid_vsync` is 0, and a vertical sync has been seen since reset. A vertical sync is an enabled sample with `vid_vsync` at 1. The first accepted pixel after a vertical sync carries `m_tuser` = 1, and every other beat carries 0. Pixels sampled before the first vertical sync after reset produce no beats.
- R5: A beat carries `m_tlast` = 1 exactly when the next enabled sample after its pixel does not accept a pixel.
- R6: `m_tdata` holds NUM_COMP fields of FIELD_W bits, where FIELD_W is COMP_W rounded up to a multiple of 8. Component i is taken from `vid_data[i*COMP_W +: COMP_W]`. It sits in bits `[i*FIELD_W +: COMP_W]`, and the bits above it in that field are 0.
- R7: A beat transfers at an enabled edge where both `m_tvalid` and `m_tready` are 1. Beats leave in the order their pixels were accepted, one beat for each accepted pixel that was not dropped.
- R8: After an edge where `m_tvalid` was 1 and no transfer occurred, `m_tvalid` stays 1 and `m_tdata`, `m_tuser` and `m_tlast` are unchanged.
- R9: The FIFO holds DEPTH beats (16 by default). Each accepted pixel enters the FIFO at the enabled edge that follows its acceptance. If the FIFO holds DEPTH beats just before that edge, the pixel is dropped, even if a transfer happens at the same edge. In that case `overflow` goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all sampling on its rising edge |
| clk_en | input | 1 | Synchronous clock enable, active high |
| rst_n | input | 1 | Synchronous reset, active low, overrides `clk_en` |
| vid_data | input | NUM_COMP*COMP_W | Pixel components, component 0 in the low bits |
| vid_active | input | 1 | Active-video qualifier |
| vid_vsync | input | 1 | Vertical-sync qualifier |
| m_tdata | output | NUM_COMP*FIELD_W | Padded beat data |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Sink ready |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |
| overflow | output | 1 | Sticky pixel-drop flag |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before anything else is checked. They also assume that `m_tready`, `clk_en` and the pixel inputs are stable around each rising edge. No assumption is made about the pairing of `vid_active` and `vid_vsync`. The bench changes every input only on the falling clock edge. It starts with reset held over several edges and with `clk_en` low part of that time. It then mixes clean line-structured frames with random enable, ready and qualifier patterns, including samples where active video and vertical sync are both high.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  // Width of one component field after rounding up to whole bytes
  function automatic int unsigned field_w(input int unsigned comp_w);
    return ((comp_w + 7) / 8) * 8;
  endfunction

  // Number of padding bits above each component
  function automatic int unsigned pad_w(input int unsigned comp_w);
    return field_w(comp_w) - comp_w;
  endfunction
endpackage

// File: rtl/vsb_framer.sv
module vsb_framer #(
  parameter int unsigned COMP_W   = 10,
  parameter int unsigned NUM_COMP = 2,
  localparam int unsigned FIELD_W = vsb_pkg::field_w(COMP_W),
  localparam int unsigned PIX_W   = NUM_COMP * COMP_W,
  localparam int unsigned DATA_W  = NUM_COMP * FIELD_W
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              active_i,
  input  logic              vsync_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              push_sof_o,
  output logic              push_eol_o
);
  logic [DATA_W-1:0] padded;
  logic              armed_q, locked_q;
  logic              hold_v_q, hold_sof_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              accept;

  // Right-justify every component inside its byte-aligned field
  for (genvar g = 0; g < NUM_COMP; g++) begin : g_pad
    if (FIELD_W > COMP_W) begin : g_wide
      assign padded[g*FIELD_W +: FIELD_W] =
        {{(FIELD_W-COMP_W){1'b0}}, pix_i[g*COMP_W +: COMP_W]};
    end else begin : g_exact
      assign padded[g*FIELD_W +: FIELD_W] = pix_i[g*COMP_W +: COMP_W];
    end
  end

  // Pixel accepted only outside vertical sync, once a frame start is known
  assign accept = active_i & ~vsync_i & (armed_q | locked_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      locked_q    <= 1'b0;
      hold_v_q    <= 1'b0;
      hold_sof_q  <= 1'b0;
      hold_data_q <= '0;
    end else if (clk_en) begin
      if (vsync_i)     armed_q <= 1'b1;
      else if (accept) armed_q <= 1'b0;
      if (accept)      locked_q <= 1'b1;
      hold_v_q    <= accept;
      hold_sof_q  <= armed_q;
      hold_data_q <= padded;
    end
  end

  // The held pixel leaves now; the current sample decides its line end
  assign push_o      = clk_en & hold_v_q;
  assign push_data_o = hold_data_q;
  assign push_sof_o  = hold_sof_q;
  assign push_eol_o  = ~accept;

  // R4: a start-of-frame beat consumes the armed state
  a_r4_sof_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && accept && armed_q && !vsync_i) |=> (!armed_q && locked_q && hold_sof_q));

  // R4: no pixel is held before a vertical sync was ever seen
  a_r4_no_pixel_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !locked_q) |-> !hold_v_q);
endmodule

// File: rtl/vsb_fifo.sv
module vsb_fifo #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         clk_en,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] rdata_o,
  output logic         overflow_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, pop, wr_ok, drop;

  assign full  = (cnt_q == FULL_CNT);
  assign pop   = clk_en & valid_o & ready_i;
  assign wr_ok = push_i & ~full;
  assign drop  = push_i & full;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clk_en) begin
      if (wr_ok) wr_q <= step(wr_q);
      if (pop)   rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(pop);
      if (drop)  ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q] <= wdata_i;
  end

  assign valid_o    = (cnt_q != '0);
  assign rdata_o    = mem[rd_q];
  assign overflow_o = ovf_q;

  // R8: a stalled head stays presented unchanged
  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop) |=> (valid_o && $stable(rdata_o)));

  // R9: the drop flag never falls outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R9: occupancy never exceeds the storage
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R9: a push into a full store raises the flag
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> overflow_o);
endmodule

// File: rtl/vsb_top.sv
module vsb_top #(
  parameter int unsigned COMP_W   = 10,
  parameter int unsigned NUM_COMP = 2,
  parameter int unsigned DEPTH    = 16,
  localparam int unsigned FIELD_W = vsb_pkg::field_w(COMP_W),
  localparam int unsigned PAD_W   = vsb_pkg::pad_w(COMP_W),
  localparam int unsigned PIX_W   = NUM_COMP * COMP_W,
  localparam int unsigned DATA_W  = NUM_COMP * FIELD_W,
  localparam int unsigned BEAT_W  = DATA_W + 2
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  vid_data,
  input  logic              vid_active,
  input  logic              vid_vsync,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tuser,
  output logic              m_tlast,
  output logic              overflow
);
  logic              fr_push, fr_sof, fr_eol;
  logic [DATA_W-1:0] fr_data;
  logic [BEAT_W-1:0] head;

  vsb_framer #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP)) i_framer (
    .clk(clk), .clk_en(clk_en), .rst_n(rst_n),
    .pix_i(vid_data), .active_i(vid_active), .vsync_i(vid_vsync),
    .push_o(fr_push), .push_data_o(fr_data),
    .push_sof_o(fr_sof), .push_eol_o(fr_eol)
  );

  vsb_fifo #(.W(BEAT_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .clk_en(clk_en), .rst_n(rst_n),
    .push_i(fr_push), .wdata_i({fr_sof, fr_eol, fr_data}),
    .ready_i(m_tready), .valid_o(m_tvalid), .rdata_o(head),
    .overflow_o(overflow)
  );

  assign m_tdata = head[DATA_W-1:0];
  assign m_tlast = head[DATA_W];
  assign m_tuser = head[DATA_W+1];

  // Mask of the padding bits above every component
  function automatic logic [DATA_W-1:0] pad_mask();
    logic [DATA_W-1:0] m = '0;
    for (int i = 0; i < int'(NUM_COMP); i++)
      for (int b = 0; b < int'(PAD_W); b++)
        m[i*FIELD_W + COMP_W + b] = 1'b1;
    return m;
  endfunction

  // R6: padding bits of a presented beat are zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ((m_tdata & pad_mask()) == '0));

  // R2: a disabled edge changes no output
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(m_tvalid) && $stable(overflow) && $stable(m_tdata)
                 && $stable(m_tuser) && $stable(m_tlast)));

  // R1 / R3: reset empties the block whatever the enable
  a_r3_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!m_tvalid && !overflow));
endmodule

// File: tb/test_vsb_top.sv
module test_vsb_top;
  localparam int CW = 10, NC = 2, DEPTH = 16;
  localparam int FW = ((CW + 7) / 8) * 8;

  logic clk = 0, clk_en = 0, rst_n = 0;
  logic [NC*CW-1:0] vid_data = '0;
  logic vid_active = 0, vid_vsync = 0, m_tready = 0;
  logic [NC*FW-1:0] m_tdata;
  logic m_tvalid, m_tuser, m_tlast, overflow;

  int checks = 0, fails = 0;

  vsb_top #(.COMP_W(CW), .NUM_COMP(NC), .DEPTH(DEPTH)) i_vsb_top (
    .clk(clk), .clk_en(clk_en), .rst_n(rst_n), .vid_data(vid_data),
    .vid_active(vid_active), .vid_vsync(vid_vsync), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tuser(m_tuser),
    .m_tlast(m_tlast), .overflow(overflow));

  always #10 clk = ~clk; // 50 MHz

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  typedef struct { longint data; bit sof; bit eol; } beat_t;
  beat_t q[$];
  bit m_hold = 0, m_hsof = 0, m_armed = 0, m_locked = 0, m_ovf = 0;
  longint m_hdata = 0;
  bit p_en = 0, p_stall = 0;
  logic [NC*FW-1:0] p_data; logic p_valid, p_user, p_last, p_ovf;

  function automatic longint widen(input logic [NC*CW-1:0] px);
    longint r = 0;
    for (int i = NC - 1; i >= 0; i--) r = r * (64'd1 << FW) + longint'((px >> (i*CW)) % (1 << CW));
    return r;
  endfunction

  always @(posedge clk) begin
    p_en = clk_en; p_stall = m_tvalid && !(m_tready && clk_en);
    p_data = m_tdata; p_valid = m_tvalid; p_user = m_tuser; p_last = m_tlast; p_ovf = overflow;
    if (!rst_n) begin
      q.delete(); m_hold = 0; m_armed = 0; m_locked = 0; m_ovf = 0; p_en = 1;
    end else if (clk_en) begin
      bit take, was_full, popped;
      take = vid_active && !vid_vsync && (m_armed || m_locked);
      was_full = (q.size() == DEPTH);
      popped = (q.size() > 0) && m_tready;
      if (popped) void'(q.pop_front());
      if (m_hold) begin
        if (was_full) m_ovf = 1;
        else q.push_back('{m_hdata, m_hsof, !take});
      end
      m_hsof = m_armed;
      if (vid_vsync) m_armed = 1; else if (take) m_armed = 0;
      if (take) m_locked = 1;
      m_hold = take; m_hdata = widen(vid_data);
    end
  end

  // Compare on every falling edge
  always @(negedge clk) if (rst_n) begin
    check(m_tvalid == (q.size() > 0), "R7 valid", m_tvalid, q.size() > 0);
    check(overflow == m_ovf, "R9 overflow", overflow, m_ovf);
    if (q.size() > 0 && m_tvalid) begin
      check(longint'(m_tdata) == q[0].data, "R6/R7 data", m_tdata, q[0].data);
      check(m_tuser == q[0].sof, "R4 tuser", m_tuser, q[0].sof);
      check(m_tlast == q[0].eol, "R5 tlast", m_tlast, q[0].eol);
    end
    if (!p_en)
      check(m_tvalid == p_valid && m_tdata == p_data && m_tuser == p_user &&
            m_tlast == p_last && overflow == p_ovf, "R2 hold", m_tvalid, p_valid);
    if (p_stall)
      check(m_tvalid && m_tdata == p_data && m_tuser == p_user && m_tlast == p_last,
            "R8 stall", m_tdata, p_data);
  end

  task automatic tick(input bit en, input bit act, input bit vs, input bit rdy);
    @(negedge clk);
    clk_en = en; vid_active = act; vid_vsync = vs; m_tready = rdy;
    vid_data = NC*CW'($urandom);
  endtask

  task automatic line(input int n, input int gap, input int rdy_pct, input int en_pct);
    for (int i = 0; i < n + gap; i++) begin
      bit en;
      do begin
        en = ($urandom % 100) < en_pct;
        tick(en, i < n, 0, ($urandom % 100) < rdy_pct);
      end while (!en);
    end
  endtask

  task automatic frame(input int lines, input int w, input int rdy_pct, input int en_pct);
    tick(1, 0, 1, 1); tick(1, 0, 1, 1); tick(1, 0, 0, 1);
    for (int l = 0; l < lines; l++) line(w, 3, rdy_pct, en_pct);
  endtask

  initial begin
    repeat (3) tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    check(!m_tvalid && !overflow, "R1 reset state", m_tvalid, 0);
    // R4: pixels before any vertical sync produce nothing
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 1);
    tick(1, 0, 0, 1); tick(1, 0, 0, 1);
    check(!m_tvalid, "R4 no beat before vsync", m_tvalid, 0);
    frame(3, 5, 100, 100);            // clean flow
    frame(2, 1, 100, 100);            // single-pixel lines
    frame(3, 7, 50, 100);             // backpressure
    frame(3, 6, 70, 60);              // enable gaps
    for (int i = 0; i < 300; i++)     // mixed qualifiers, incl. active with vsync
      tick(($urandom % 4) != 0, $urandom % 2, ($urandom % 9) == 0, $urandom % 2);
    repeat (40) tick(1, 0, 0, 1);
    check(!m_tvalid, "R7 drained", m_tvalid, 0);
    // R9: fill while the sink stalls
    frame(1, 24, 0, 100);
    check(overflow, "R9 overflow set", overflow, 1);
    repeat (30) tick(1, 0, 0, 1);
    check(overflow, "R9 overflow sticky", overflow, 1);
    // R3: reset with the enable low
    tick(0, 0, 0, 0); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check(!m_tvalid && !overflow, "R3 reset under disabled enable", overflow, 0);
    frame(2, 4, 80, 90);
    repeat (40) tick(1, 0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule